// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

The block drives the capture path of one 8-channel logic analyzer bank backed by an external 32K x 8 SRAM. It runs entirely in the bank's own sample clock domain. Once armed, it stores one sample per clock into a circular buffer. The address counter is synchronous and wraps around, so the buffer always holds the most recent samples.

An 8-bit comparator with a per-bit enable mask detects the trigger. The first match after arming records the SRAM address of the triggering sample. A programmable post-trigger count then sets how many further samples are stored. After that, writes stop, the address freezes and a done flag is raised. The host can move the stored window anywhere between all pre-trigger and almost all post-trigger.

While idle or done, the host can load and step the SRAM address with write-enable held low. This lets it read the buffer back through the SRAM data bus.

Top module: `la_capture`

## Requirements
- R1: After reset the block is idle: `armed_o`, `triggered_o`, `done_o` and `sram_we_o` are low, and `sram_addr_o` and `trig_addr_o` are 0.
- R2: A sample matches when every bit with a 1 in `trig_en_i` equals the same bit of `trig_pat_i`. Bits with a 0 in `trig_en_i` are don't-care, so an all-zero enable matches any sample.
- R3: Matches while not armed are ignored. Only the first match after an arm fires the trigger, and later matches leave `trig_addr_o` and the capture unchanged.
- R4: `arm_i` high at a clock edge while idle or done starts a capture: the address is cleared to 0, `done_o` and `triggered_o` are cleared, and `armed_o` is set. `arm_i` is ignored while a capture is running.
- R5: While armed, each clock writes `sample_i` (on `sram_wdata_o`) to `sram_addr_o` with `sram_we_o` high. The address then advances by one, modulo 32768.
- R6: When the trigger fires, `trig_addr_o` takes the address to which the triggering sample was written.
- R7: With a post-trigger count N > 0 (value of `post_cnt_i` in the trigger cycle), exactly N samples are written after the triggering sample. After that, `done_o` rises, `armed_o` and `sram_we_o` fall, and the address stays on the last written location.
- R8: With N = 0, only the triggering sample is written, and `done_o` rises at the same edge as `triggered_o`.
- R9: While idle or done, `rd_load_i` loads `rd_addr_i` into the address, and `rd_step_i` advances it by one with wrap. Load wins over step, and `sram_we_o` stays low.
- R10: `done_o` and `triggered_o` stay high until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Start a capture |
| sample_i | input | 8 | Channel sample |
| trig_pat_i | input | 8 | Trigger pattern |
| trig_en_i | input | 8 | Per-bit trigger compare enable |
| post_cnt_i | input | 15 | Samples to store after the trigger |
| rd_load_i | input | 1 | Load readout address |
| rd_addr_i | input | 15 | Readout address value |
| rd_step_i | input | 1 | Advance readout address |
| sram_addr_o | output | 15 | SRAM address |
| sram_wdata_o | output | 8 | SRAM write data |
| sram_we_o | output | 1 | SRAM write enable, active high |
| armed_o | output | 1 | Capture running |
| triggered_o | output | 1 | Trigger has fired |
| done_o | output | 1 | Capture finished |
| trig_addr_o | output | 15 | Address of the triggering sample |

## Verification
The assertions assume that the host leaves `rd_load_i` and `rd_step_i` alone during a capture, where they are ignored anyway. They also assume that any freeze check excludes the cycles in which the host moves the address or re-arms. The stimulus changes all inputs only on the falling clock edge, so setup toward the rising edge always holds. Read controls are driven only once `done_o` is high or before the first arm. A wrap run stores more than 32768 samples before triggering, and then uses the maximum post-trigger count.

// File: rtl/la_pkg.sv
`timescale 1ns/1ps
package la_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;
endpackage

// File: rtl/la_trig_match.sv
`timescale 1ns/1ps
module la_trig_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] sample_i,
  input  logic [W-1:0] pat_i,
  input  logic [W-1:0] en_i,
  output logic         hit_o
);
  logic [W-1:0] bit_ok;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_ok[i] = ~en_i[i] | (sample_i[i] == pat_i[i]);
  end
  assign hit_o = &bit_ok;
endmodule

// File: rtl/la_addr_gen.sv
`timescale 1ns/1ps
module la_addr_gen #(
  parameter int AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  // priority: clear, load, increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (load_i) addr_q <= load_val_i;
    else if (inc_i)  addr_q <= addr_q + 1'b1;
  end
  assign addr_o = addr_q;

  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !load_i && addr_q == '1) |=> addr_q == '0);
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i && !load_i) |=> $stable(addr_q));
endmodule

// File: rtl/la_post_ctr.sv
`timescale 1ns/1ps
module la_post_ctr #(
  parameter int CW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic          dec_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end
  assign last_o = (cnt_q == CW'(1));

  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> cnt_q != '0);
endmodule

// File: rtl/la_capture.sv
`timescale 1ns/1ps
module la_capture
  import la_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic [DW-1:0] sample_i,
  input  logic [DW-1:0] trig_pat_i,
  input  logic [DW-1:0] trig_en_i,
  input  logic [AW-1:0] post_cnt_i,
  input  logic          rd_load_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          rd_step_i,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_wdata_o,
  output logic          sram_we_o,
  output logic          armed_o,
  output logic          triggered_o,
  output logic          done_o,
  output logic [AW-1:0] trig_addr_o
);
  cap_state_e    st_q, st_d;
  logic          hit, capture, fire, post_zero, last, arm_ok;
  logic          addr_inc, addr_load;
  logic [AW-1:0] addr, trig_addr_q;

  la_trig_match #(.W(DW)) u_match (
    .sample_i(sample_i), .pat_i(trig_pat_i), .en_i(trig_en_i), .hit_o(hit)
  );

  assign capture   = (st_q == ST_PRE) || (st_q == ST_POST);
  assign fire      = (st_q == ST_PRE) && hit;
  assign post_zero = (post_cnt_i == '0);
  assign arm_ok    = arm_i && !capture;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (arm_i) st_d = ST_PRE;
      ST_PRE:           if (hit)   st_d = post_zero ? ST_DONE : ST_POST;
      ST_POST:          if (last)  st_d = ST_DONE;
      default:          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // address freezes on the last written sample
  assign addr_inc  = ((st_q == ST_PRE) && !(hit && post_zero)) ||
                     ((st_q == ST_POST) && !last) ||
                     (!capture && rd_step_i);
  assign addr_load = !capture && rd_load_i;

  la_addr_gen #(.AW(AW)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(arm_ok), .load_i(addr_load),
    .load_val_i(rd_addr_i), .inc_i(addr_inc), .addr_o(addr)
  );

  la_post_ctr #(.CW(AW)) u_post (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(fire), .val_i(post_cnt_i),
    .dec_i(st_q == ST_POST), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     trig_addr_q <= '0;
    else if (arm_ok) trig_addr_q <= '0;
    else if (fire)   trig_addr_q <= addr;
  end

  assign sram_addr_o  = addr;
  assign sram_wdata_o = sample_i;
  assign sram_we_o    = capture;
  assign armed_o      = capture;
  assign triggered_o  = (st_q == ST_POST) || (st_q == ST_DONE);
  assign done_o       = (st_q == ST_DONE);
  assign trig_addr_o  = trig_addr_q;

  a_r3_fire_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(triggered_o) |-> $past(armed_o && hit));
  a_r6_trig_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(triggered_o) |-> trig_addr_o == $past(sram_addr_o));
  a_r7_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i && !rd_load_i && !rd_step_i) |=> $stable(sram_addr_o));
  a_r9_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_o |-> !sram_we_o);
  a_r10_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |=> (done_o && triggered_o));
  a_r4_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && armed_o));
endmodule

// File: tb/la_capture_test.sv
`timescale 1ns/1ps
module la_capture_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arm_i = 1'b0;
  logic [7:0]  sample_i = '0;
  logic [7:0]  trig_pat_i = '0;
  logic [7:0]  trig_en_i = '0;
  logic [14:0] post_cnt_i = '0;
  logic        rd_load_i = 1'b0;
  logic [14:0] rd_addr_i = '0;
  logic        rd_step_i = 1'b0;
  logic [14:0] sram_addr_o, trig_addr_o;
  logic [7:0]  sram_wdata_o;
  logic        sram_we_o, armed_o, triggered_o, done_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] mem [int];

  always #2.5 clk_i = ~clk_i;

  la_capture uut (.*);

  // external SRAM model
  always @(posedge clk_i) if (sram_we_o) mem[int'(sram_addr_o)] = sram_wdata_o;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle, return just after the edge
  task automatic cyc(logic [7:0] d, logic a = 1'b0, logic ld = 1'b0, logic st = 1'b0);
    @(negedge clk_i);
    sample_i = d; arm_i = a; rd_load_i = ld; rd_step_i = st;
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_arm(logic [7:0] pat, logic [7:0] en, logic [14:0] n);
    trig_pat_i = pat; trig_en_i = en; post_cnt_i = n;
    mem.delete();
    cyc(8'h00, 1'b1);
  endtask

  task automatic t_reset();
    check("R1 armed", armed_o, 0);
    check("R1 trig", triggered_o, 0);
    check("R1 done", done_o, 0);
    check("R1 we", sram_we_o, 0);
    check("R1 addr", sram_addr_o, 0);
    check("R1 taddr", trig_addr_o, 0);
  endtask

  task automatic t_idle_ignore();
    trig_pat_i = 8'hA5; trig_en_i = 8'hFF;
    cyc(8'hA5);
    check("R3 idle match ignored", triggered_o, 0);
    check("R9 idle no write", sram_we_o, 0);
  endtask

  task automatic t_masked();
    do_arm(8'hA5, 8'hF0, 15'd3);
    check("R4 armed", armed_o, 1);
    check("R4 addr cleared", sram_addr_o, 0);
    check("R5 we", sram_we_o, 1);
    cyc(8'h11); cyc(8'h22); cyc(8'h5A);
    check("R2 masked mismatch", triggered_o, 0);
    check("R5 addr advance", sram_addr_o, 3);
    cyc(8'hA3);
    check("R2 masked match", triggered_o, 1);
    check("R6 trig addr", trig_addr_o, 3);
    cyc(8'hA7);
    check("R3 second match ignored", trig_addr_o, 3);
    cyc(8'h33);
    check("R7 not yet done", done_o, 0);
    cyc(8'h44);
    check("R7 done", done_o, 1);
    check("R7 armed low", armed_o, 0);
    check("R7 we low", sram_we_o, 0);
    check("R7 freeze addr", sram_addr_o, 6);
    cyc(8'hA5); cyc(8'h99);
    check("R7 still frozen", sram_addr_o, 6);
    check("R10 done held", done_o, 1);
    check("R10 trig held", triggered_o, 1);
    check("R5 mem0", mem[0], 8'h11);
    check("R5 mem2", mem[2], 8'h5A);
    check("R6 mem trig", mem[3], 8'hA3);
    check("R7 mem6", mem[6], 8'h44);
    check("R7 no extra write", mem.exists(7), 0);
  endtask

  task automatic t_readout();
    cyc(8'h00, 1'b0, 1'b1);  // rd_addr_i defaults to 0
    check("R9 load", sram_addr_o, 0);
    check("R9 we low", sram_we_o, 0);
    cyc(8'h00, 1'b0, 1'b0, 1'b1);
    check("R9 step", sram_addr_o, 1);
    check("R9 data at addr", mem[int'(sram_addr_o)], 8'h22);
    rd_addr_i = 15'h7FFF;
    cyc(8'h00, 1'b0, 1'b1, 1'b1);
    check("R9 load beats step", sram_addr_o, 15'h7FFF);
    cyc(8'h00, 1'b0, 1'b0, 1'b1);
    check("R9 step wraps", sram_addr_o, 0);
    check("R10 done during readout", done_o, 1);
  endtask

  task automatic t_zero_post();
    do_arm(8'h00, 8'h00, 15'd0);
    check("R4 done cleared", done_o, 0);
    check("R4 trig cleared", triggered_o, 0);
    cyc(8'h77);
    check("R2 zero enable match", triggered_o, 1);
    check("R8 done same edge", done_o, 1);
    check("R8 addr frozen", sram_addr_o, 0);
    check("R8 we low", sram_we_o, 0);
    cyc(8'h88);
    check("R8 single write", mem.exists(1), 0);
    check("R8 mem0", mem[0], 8'h77);
  endtask

  task automatic t_arm_busy();
    do_arm(8'hFF, 8'hFF, 15'd1);
    cyc(8'h01); cyc(8'h02);
    cyc(8'h03, 1'b1);
    check("R4 arm ignored addr", sram_addr_o, 3);
    check("R4 arm ignored state", armed_o, 1);
    cyc(8'hFF); cyc(8'h04);
    check("R7 N=1 done", done_o, 1);
    check("R7 N=1 addr", sram_addr_o, 4);
  endtask

  task automatic t_wrap();
    do_arm(8'hFF, 8'hFF, 15'd32767);
    for (int i = 0; i < 32770; i++) cyc(8'h00);
    check("R5 wrap addr", sram_addr_o, 2);
    check("R3 no match yet", triggered_o, 0);
    cyc(8'hFF);
    check("R6 wrap trig addr", trig_addr_o, 2);
    for (int i = 0; i < 32766; i++) cyc(8'(i));
    check("R7 max not done", done_o, 0);
    cyc(8'hC3);
    check("R7 max done", done_o, 1);
    check("R7 max final addr", sram_addr_o, 1);
    check("R7 max last data", mem[1], 8'hC3);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #7 rst_ni = 1'b1;
    #1;
    t_reset();
    t_idle_ignore();
    t_masked();
    t_readout();
    t_zero_post();
    t_arm_busy();
    t_wrap();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule